// File: doc/BRIEF.md
# Page-Offset-Indexed Data Cache with Physical Tags

This block is a direct-mapped data cache placed beside a translation buffer. The set index is taken only from address bits that translation leaves unchanged, the displacement inside a page. The line array can therefore be read with the untranslated address in the same cycle that the translation buffer produces the physical page number. In the following cycle the stored physical tag is compared with that page number.

Each accepted access ends in one of three ways. If the translation buffer hit and a valid line carries a matching tag, the word goes back to the requester. If the translation buffer hit and the line does not match, the cache issues a line read to memory at the translated physical address. It writes the returned word into the line with its new tag and completes the access one cycle later. If the translation buffer missed, the cache raises a one-cycle request for a full translation, leaves the array unchanged and returns to idle.

The default geometry is 1024 lines of 4 bytes (4 KB) against a 4 KB page. Index bits [11:2] and byte-offset bits [1:0] fill the 12-bit page displacement exactly. The tag is the 20-bit physical page number. A build whose index and offset together are wider than the page displacement is rejected at elaboration.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid and `req_ready` is 1, with `resp_valid`, `xlate_req` and `mem_rd_valid` all 0. The first access to any address with a translation hit goes to memory.
- R2: The line is selected by `req_vaddr[11:2]` alone. Two accesses that differ only in bits [1:0], or only in virtual page bits [31:12], reach the same line and hit when the physical page number matches.
- R3: An accepted access with `tlb_hit`=1 to a valid line whose tag equals `tlb_ppn` raises `resp_valid` with the stored word in the cycle after acceptance. No memory read is issued.
- R4: An accepted access with `tlb_hit`=1 that does not hit raises `mem_rd_valid` two cycles after acceptance, with `mem_rd_addr` = {`tlb_ppn`, `req_vaddr[11:2]`, 2'b00}. Both are held unchanged until `mem_rsp_valid` is seen.
- R5: An accepted access with `tlb_hit`=0 raises `xlate_req` for exactly one cycle, in the cycle after acceptance. It produces no response and no memory read, and the line's contents and validity are left as they were.
- R6: The cycle after `mem_rsp_valid` is seen during a refill, `resp_valid` is 1 with `resp_data` equal to `mem_rsp_data`. The line then holds that word under the new tag, so a repeat access hits.
- R7: An access whose index matches a valid line but whose physical page number differs is a miss. Its refill replaces the line, so a later access with the old page number misses.
- R8: `req_ready` drops in the cycle after a request is accepted and stays 0 until the access completes. Requests presented while `req_ready` is 0 are ignored.
- R9: At most one of `resp_valid`, `xlate_req` and `mem_rd_valid` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_vaddr | input | 32 | Virtual byte address of the access |
| tlb_hit | input | 1 | Translation buffer hit, valid alongside the request |
| tlb_ppn | input | 20 | Physical page number from the translation buffer |
| resp_valid | output | 1 | Read data returned this cycle |
| resp_data | output | 32 | Returned word |
| xlate_req | output | 1 | Translation buffer missed; full translation needed |
| mem_rd_valid | output | 1 | Line read request to memory, held until answered |
| mem_rd_addr | output | 32 | Physical line address of the memory read |
| mem_rsp_valid | input | 1 | Memory returns the requested line this cycle |
| mem_rsp_data | input | 32 | Line data from memory |

## Verification
The assertions assume that the memory port answers only while `mem_rd_valid` is high, with a single `mem_rsp_valid` pulse per read. They also assume that `tlb_hit` and `tlb_ppn` belong to the request they arrive with, in the accepting cycle. The bench's memory model keeps to this: it waits until it sees the read, checks that the read is held for a cycle, and then answers once. It also drives translation inputs only together with a request. The bench presents one stray request during a refill to show that it is ignored, and holds `mem_rsp_valid` low at all other times.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int PAGE_OFF_W = 12;
    localparam int LINE_BYTES = 4;
    localparam int LINES      = 1024;
    localparam int DATA_W     = 8 * LINE_BYTES;

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int PPN_W = PA_W - PAGE_OFF_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [PPN_W-1:0]  ppn_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PA_W-1:0]   paddr_t;
    typedef logic [VA_W-1:0]   vaddr_t;

    typedef struct packed {
        logic  valid;
        ppn_t  tag;
        word_t data;
    } line_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_REFILL,
        ST_DONE
    } state_e;

    function automatic idx_t va_index(input vaddr_t va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic paddr_t line_paddr(input ppn_t ppn, input idx_t idx);
        logic [PAGE_OFF_W-1:0] disp;
        disp = '0;
        disp[OFF_W +: IDX_W] = idx;
        return {ppn, disp};
    endfunction
endpackage

// File: rtl/vipt_line_store.sv
module vipt_line_store
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  ppn_t  wr_tag,
    input  word_t wr_data
);
    logic [LINES-1:0] vld;
    ppn_t  tag_mem [LINES];
    word_t dat_mem [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld           <= '0;
            rd_line.valid <= 1'b0;
        end else begin
            if (wr_en) vld[wr_idx] <= 1'b1;
            if (rd_en) rd_line.valid <= vld[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            dat_mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_line.tag  <= tag_mem[rd_idx];
            rd_line.data <= dat_mem[rd_idx];
        end
    end

    // R6: a written line reads back valid at its index
    p_fill_sets_valid_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld[$past(wr_idx)]);
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  idx_t   req_idx,
    input  logic   tlb_hit,
    input  ppn_t   tlb_ppn,
    output logic   req_ready,
    output logic   rd_en,
    input  line_t  rd_line,
    output logic   resp_valid,
    output word_t  resp_data,
    output logic   xlate_req,
    output logic   mem_rd_valid,
    output paddr_t mem_rd_addr,
    input  logic   mem_rsp_valid,
    input  word_t  mem_rsp_data,
    output logic   wr_en,
    output idx_t   wr_idx,
    output ppn_t   wr_tag,
    output word_t  wr_data
);
    state_e state;
    idx_t   idx_q;
    ppn_t   ppn_q;
    logic   th_q;
    word_t  fill_q;
    logic   tag_match;

    assign tag_match    = rd_line.valid && (rd_line.tag == ppn_q);
    assign req_ready    = (state == ST_IDLE);
    assign rd_en        = req_ready && req_valid;
    assign xlate_req    = (state == ST_LOOKUP) && !th_q;
    assign resp_valid   = ((state == ST_LOOKUP) && th_q && tag_match) || (state == ST_DONE);
    assign resp_data    = (state == ST_DONE) ? fill_q : rd_line.data;
    assign mem_rd_valid = (state == ST_REFILL);
    assign mem_rd_addr  = line_paddr(ppn_q, idx_q);
    assign wr_en        = (state == ST_REFILL) && mem_rsp_valid;
    assign wr_idx       = idx_q;
    assign wr_tag       = ppn_q;
    assign wr_data      = mem_rsp_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            ppn_q  <= '0;
            th_q   <= 1'b0;
            fill_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    idx_q <= req_idx;
                    ppn_q <= tlb_ppn;
                    th_q  <= tlb_hit;
                    state <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    if (th_q && !tag_match) state <= ST_REFILL;
                    else                    state <= ST_IDLE;
                end
                ST_REFILL: if (mem_rsp_valid) begin
                    fill_q <= mem_rsp_data;
                    state  <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a single outcome per cycle
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_valid, xlate_req, mem_rd_valid}));
    // R4: memory request held steady until answered
    p_rd_held_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));
    // R6: answer completes the access next cycle with the returned word
    p_fill_resp_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && mem_rsp_valid) |=> (resp_valid && resp_data == $past(mem_rsp_data)));
    // R8: busy after acceptance
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R5: translation request lasts one cycle
    p_xlate_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        xlate_req |=> !xlate_req);
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        tlb_hit,
    input  logic [19:0] tlb_ppn,
    output logic        resp_valid,
    output logic [31:0] resp_data,
    output logic        xlate_req,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    if (OFF_W + IDX_W > PAGE_OFF_W) begin : g_bad_geometry
        $error("cache index and offset exceed the page displacement width");
    end

    idx_t  req_idx;
    logic  rd_en;
    line_t rd_line;
    logic  wr_en;
    idx_t  wr_idx;
    ppn_t  wr_tag;
    word_t wr_data;

    assign req_idx = va_index(req_vaddr);

    vipt_line_store u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_idx  (req_idx),
        .rd_line (rd_line),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .wr_data (wr_data)
    );

    vipt_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_idx       (req_idx),
        .tlb_hit       (tlb_hit),
        .tlb_ppn       (tlb_ppn),
        .req_ready     (req_ready),
        .rd_en         (rd_en),
        .rd_line       (rd_line),
        .resp_valid    (resp_valid),
        .resp_data     (resp_data),
        .xlate_req     (xlate_req),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_tag        (wr_tag),
        .wr_data       (wr_data)
    );

    // R1: idle and silent right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (req_ready && !resp_valid && !xlate_req && !mem_rd_valid));
endmodule

// File: tb/vipt_cache_tb_top.sv
module vipt_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        tlb_hit;
    logic [19:0] tlb_ppn;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        xlate_req;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int n_chk = 0;
    int n_bad = 0;

    localparam int K_NONE = 0, K_HIT = 1, K_XLATE = 2, K_FILL = 3;

    always #5 clk = ~clk;

    vipt_cache dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .resp_valid(resp_valid), .resp_data(resp_data), .xlate_req(xlate_req),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    function automatic logic [31:0] exp_paddr(input logic [19:0] ppn, input logic [31:0] va);
        return {ppn, va[11:2], 2'b00};
    endfunction

    // One access; memory is served with fill when a read appears.
    task automatic run(input logic [31:0] va, input bit th, input logic [19:0] ppn,
                       input logic [31:0] fill, output int kind,
                       output logic [31:0] data, output logic [31:0] maddr);
        kind = K_NONE; data = '0; maddr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; tlb_hit = th; tlb_ppn = ppn;
        @(negedge clk);
        req_valid = 1'b0; tlb_hit = 1'b0; tlb_ppn = '0;
        #1;
        chk(!req_ready, "R8", "ready during lookup", 32'(req_ready), 32'd0);
        if (resp_valid) begin
            kind = K_HIT; data = resp_data;
        end else if (xlate_req) begin
            kind = K_XLATE;
        end else begin
            @(negedge clk); #1;
            if (mem_rd_valid) begin
                maddr = mem_rd_addr;
                @(negedge clk); #1;
                chk(mem_rd_valid && mem_rd_addr == maddr, "R4", "read held",
                    mem_rd_addr, maddr);
                mem_rsp_valid = 1'b1; mem_rsp_data = fill;
                @(negedge clk);
                mem_rsp_valid = 1'b0; mem_rsp_data = '0;
                #1;
                if (resp_valid) begin
                    kind = K_FILL; data = resp_data;
                end
            end
        end
    endtask

    task automatic t_reset;
        int k; logic [31:0] d, a;
        chk(req_ready && !resp_valid && !xlate_req && !mem_rd_valid, "R1", "idle after reset",
            {28'd0, req_ready, resp_valid, xlate_req, mem_rd_valid}, 32'h8);
        run(32'h0000_0040, 1'b1, 20'h00001, 32'h1111_0040, k, d, a);
        chk(k == K_FILL, "R1", "cold access goes to memory", k, K_FILL);
    endtask

    task automatic t_miss_and_hit;
        int k; logic [31:0] d, a;
        run(32'h7000_0ABC, 1'b1, 20'h12345, 32'hCAFE_0001, k, d, a);
        chk(k == K_FILL, "R4", "miss outcome", k, K_FILL);
        chk(a == exp_paddr(20'h12345, 32'h7000_0ABC), "R4", "read address",
            a, exp_paddr(20'h12345, 32'h7000_0ABC));
        chk(d == 32'hCAFE_0001, "R6", "fill data returned", d, 32'hCAFE_0001);
        run(32'h7000_0ABC, 1'b1, 20'h12345, 32'h0, k, d, a);
        chk(k == K_HIT, "R3", "repeat hits", k, K_HIT);
        chk(d == 32'hCAFE_0001, "R3", "hit data", d, 32'hCAFE_0001);
    endtask

    task automatic t_index_bits;
        int k; logic [31:0] d, a;
        run(32'h7000_0ABF, 1'b1, 20'h12345, 32'h0, k, d, a);
        chk(k == K_HIT && d == 32'hCAFE_0001, "R2", "offset bits ignored", d, 32'hCAFE_0001);
        run(32'h0BAD_DABC, 1'b1, 20'h12345, 32'h0, k, d, a);
        chk(k == K_HIT && d == 32'hCAFE_0001, "R2", "virtual page bits ignored", d, 32'hCAFE_0001);
    endtask

    task automatic t_tlb_miss;
        int k; logic [31:0] d, a;
        run(32'h7000_0ABC, 1'b0, 20'h12345, 32'h0, k, d, a);
        chk(k == K_XLATE, "R5", "translation requested", k, K_XLATE);
        @(negedge clk); #1;
        chk(!xlate_req && !resp_valid && !mem_rd_valid, "R5", "single pulse",
            32'(xlate_req), 32'd0);
        run(32'h7000_0ABC, 1'b1, 20'h12345, 32'h0, k, d, a);
        chk(k == K_HIT && d == 32'hCAFE_0001, "R5", "line untouched", d, 32'hCAFE_0001);
        run(32'h0000_0800, 1'b0, 20'h00042, 32'h0, k, d, a);
        chk(k == K_XLATE, "R5", "cold translation miss", k, K_XLATE);
        run(32'h0000_0800, 1'b1, 20'h00042, 32'h4242_0800, k, d, a);
        chk(k == K_FILL, "R5", "no fill on translation miss", k, K_FILL);
    endtask

    task automatic t_conflict;
        int k; logic [31:0] d, a;
        run(32'h7000_0ABC, 1'b1, 20'h54321, 32'hBEEF_0002, k, d, a);
        chk(k == K_FILL, "R7", "other page misses", k, K_FILL);
        chk(a == exp_paddr(20'h54321, 32'h7000_0ABC), "R7", "conflict read address",
            a, exp_paddr(20'h54321, 32'h7000_0ABC));
        run(32'h7000_0ABC, 1'b1, 20'h54321, 32'h0, k, d, a);
        chk(k == K_HIT && d == 32'hBEEF_0002, "R7", "new page hits", d, 32'hBEEF_0002);
        run(32'h7000_0ABC, 1'b1, 20'h12345, 32'hCAFE_0003, k, d, a);
        chk(k == K_FILL, "R7", "old page evicted", k, K_FILL);
    endtask

    task automatic t_busy;
        logic [31:0] a;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_0100; tlb_hit = 1'b1; tlb_ppn = 20'h00077;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk); #1;
        chk(mem_rd_valid && !req_ready, "R8", "refill busy", 32'(req_ready), 32'd0);
        a = mem_rd_addr;
        req_valid = 1'b1; req_vaddr = 32'h0000_0200; tlb_hit = 1'b0; tlb_ppn = 20'h00088;
        @(negedge clk);
        req_valid = 1'b0; tlb_hit = 1'b0;
        #1;
        chk(mem_rd_valid && mem_rd_addr == a && !xlate_req, "R8", "stray request ignored",
            mem_rd_addr, a);
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h7777_0100;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1;
        chk(resp_valid && resp_data == 32'h7777_0100, "R6", "busy refill completes",
            resp_data, 32'h7777_0100);
        @(negedge clk); #1;
        chk(req_ready && !resp_valid && !xlate_req && !mem_rd_valid, "R8", "quiet after",
            32'(req_ready), 32'd1);
    endtask

    task automatic t_many_lines;
        int k; logic [31:0] d, a;
        for (int i = 0; i < 6; i++) begin
            run(32'h0000_0C00 + 32'(i * 4), 1'b1, 20'h00100 + 20'(i), 32'hD000_0000 + 32'(i), k, d, a);
            chk(k == K_FILL, "R6", "multi fill", k, K_FILL);
        end
        for (int i = 0; i < 6; i++) begin
            run(32'h0000_0C00 + 32'(i * 4), 1'b1, 20'h00100 + 20'(i), 32'h0, k, d, a);
            chk(k == K_HIT && d == 32'hD000_0000 + 32'(i), "R3", "multi hit",
                d, 32'hD000_0000 + 32'(i));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; tlb_hit = 1'b0; tlb_ppn = '0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_miss_and_hit();
        t_index_bits();
        t_tlb_miss();
        t_conflict();
        t_busy();
        t_many_lines();
        summary();
        $finish;
    end
endmodule